// File: doc/BRIEF.md
# Deinterleaving Half-to-Single Vector Widener

This block takes one packed vector of half-precision floating-point values, VL bits wide, and turns every element into an exact single-precision value. The results are split between two destination vectors, each VL bits wide. Elements from even source positions fill the first destination. Elements from odd source positions fill the second. Both destinations therefore hold VL/32 single-precision lanes, and together they form a consecutive register pair.

The datapath is a single registered stage. An operation is presented with `valid_i`. One clock later both destination vectors and the invalid-operation flag are updated and `valid_o` is raised. The widening is always exact, so nothing is rounded. A mode input selects whether NaN results keep their payload or collapse to the canonical default NaN. The flag is the OR, over every lane of the operation, of a signaling-NaN input.

VL is a parameter and must be a multiple of 128.

Top module: `fp16_deint_widen`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by one clock. A result appears on the outputs in the cycle after its operation is accepted. Reset clears `valid_o`, both destinations and `invalid_o` to zero.
- R2: Source half lane 2p, which occupies bits [32p+15:32p], becomes single lane p of `dst0_o`, at bits [32p+31:32p].
- R3: Source half lane 2p+1, which occupies bits [32p+31:32p+16], becomes single lane p of `dst1_o`, at bits [32p+31:32p].
- R4: A normal half value (exponent field 1..30) keeps its sign. Its exponent field is raised by 112, and its 10-bit fraction becomes the top 10 bits of the 23-bit fraction, with zeros below.
- R5: A half subnormal (exponent 0, fraction nonzero) becomes the exactly equal single normal number. A zero of either sign becomes a single zero of the same sign.
- R6: A half infinity (exponent 31, fraction 0) becomes a single infinity of the same sign, 0x7F800000 with the sign in bit 31.
- R7: With `dn_mode_i` low, a NaN input (exponent 31, fraction nonzero) produces the input sign, exponent 0xFF, fraction bit 22 set, half fraction bits 8..0 in single fraction bits 21..13, and zeros below. A signaling NaN (half fraction bit 9 clear) is quieted this way.
- R8: With `dn_mode_i` high, every NaN input produces 0x7FC00000. Non-NaN lanes are unaffected by the mode.
- R9: `invalid_o` is set for an operation exactly when at least one of its source lanes is a signaling NaN. A quiet NaN does not set it.
- R10: While `valid_i` is low, `dst0_o`, `dst1_o` and `invalid_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on `src_i` |
| src_i | input | VL | Packed half-precision source lanes |
| dn_mode_i | input | 1 | Default-NaN mode |
| valid_o | output | 1 | Destinations updated this cycle |
| dst0_o | output | VL | Widened even source lanes |
| dst1_o | output | VL | Widened odd source lanes |
| invalid_o | output | 1 | Invalid-operation flag for the last operation |

## Verification
The assertions take for granted that `valid_i` stays low for as long as reset is applied. They also assume `src_i` and `dn_mode_i` carry known values in every cycle in which `valid_i` is high. Without these conditions the one-cycle relation on `valid_o` and the per-lane checks against the sampled source would compare against undefined history.

The stimulus meets them in three ways. It holds `valid_i` low through reset. It drives every input only at falling edges, from fully specified vectors. It walks all 65536 half encodings in both NaN modes, so every assertion antecedent is reached with legal data.

// File: rtl/fdw_pkg.sv
package fdw_pkg;
  localparam logic [7:0]  EXP_REBIAS = 8'd112;
  localparam logic [7:0]  SUB_EXP_BASE = 8'd103;
  localparam logic [31:0] DEFAULT_NAN = 32'h7FC0_0000;

  typedef struct packed {
    logic [31:0] val;
    logic        snan;
  } lane_res_t;
endpackage

// File: rtl/fdw_msb.sv
module fdw_msb #(
  parameter int W  = 10,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++)
      if (vec_i[i]) pos_o = PW'(i);
  end
endmodule

// File: rtl/fdw_lane.sv
module fdw_lane
  import fdw_pkg::*;
(
  input  logic [15:0] half_i,
  input  logic        dn_i,
  output lane_res_t   res_o
);
  logic       sgn;
  logic [4:0] ex;
  logic [9:0] fr;
  logic [3:0] lead;
  logic [23:0] norm;

  assign sgn = half_i[15];
  assign ex  = half_i[14:10];
  assign fr  = half_i[9:0];

  fdw_msb #(.W(10)) u_msb (.vec_i(fr), .pos_o(lead));

  // leading one of a subnormal lands on bit 23 and is dropped
  assign norm = {1'b0, fr, 13'b0} << (4'd10 - lead);

  always_comb begin
    res_o.snan = 1'b0;
    if (ex == 5'h1F) begin
      if (fr == '0) begin
        res_o.val = {sgn, 8'hFF, 23'h0};
      end else begin
        res_o.snan = ~fr[9];
        res_o.val  = dn_i ? DEFAULT_NAN : {sgn, 8'hFF, 1'b1, fr[8:0], 13'h0};
      end
    end else if (ex == 5'h00) begin
      if (fr == '0) res_o.val = {sgn, 31'h0};
      else          res_o.val = {sgn, {4'b0, lead} + SUB_EXP_BASE, norm[22:0]};
    end else begin
      res_o.val = {sgn, {3'b0, ex} + EXP_REBIAS, fr, 13'h0};
    end
  end
endmodule

// File: rtl/fp16_deint_widen.sv
module fp16_deint_widen
  import fdw_pkg::*;
#(
  parameter int VL = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [VL-1:0] src_i,
  input  logic          dn_mode_i,
  output logic          valid_o,
  output logic [VL-1:0] dst0_o,
  output logic [VL-1:0] dst1_o,
  output logic          invalid_o
);
  localparam int NPAIR = VL / 32;

  if (VL % 128 != 0) begin : g_bad_vl
    $error("fp16_deint_widen: VL must be a multiple of 128");
  end

  logic [VL-1:0]      nxt0, nxt1;
  logic [NPAIR-1:0]   snan_e, snan_o;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    lane_res_t r_even, r_odd;
    fdw_lane u_even (.half_i(src_i[32*p +: 16]),      .dn_i(dn_mode_i), .res_o(r_even));
    fdw_lane u_odd  (.half_i(src_i[32*p + 16 +: 16]), .dn_i(dn_mode_i), .res_o(r_odd));
    assign nxt0[32*p +: 32] = r_even.val;
    assign nxt1[32*p +: 32] = r_odd.val;
    assign snan_e[p] = r_even.snan;
    assign snan_o[p] = r_odd.snan;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      dst0_o    <= '0;
      dst1_o    <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst0_o    <= nxt0;
        dst1_o    <= nxt1;
        invalid_o <= |{snan_e, snan_o};
      end
    end
  end
endmodule

// File: rtl/fp16_deint_widen_chk.sv
module fp16_deint_widen_chk #(
  parameter int VL = 128
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [VL-1:0] src_i,
  input logic          dn_mode_i,
  input logic          valid_o,
  input logic [VL-1:0] dst0_o,
  input logic [VL-1:0] dst1_o,
  input logic          invalid_o
);
  localparam int NPAIR = VL / 32;
  localparam int NHALF = VL / 16;

  logic any_snan;
  always_comb begin
    any_snan = 1'b0;
    for (int i = 0; i < NHALF; i++)
      if (src_i[16*i+10 +: 5] == 5'h1F && src_i[16*i +: 10] != '0 && !src_i[16*i+9])
        any_snan = 1'b1;
  end

  assert_valid_delay_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(dst0_o) && $stable(dst1_o) && $stable(invalid_o));

  assert_flag_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && any_snan |=> invalid_o);

  assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !any_snan |=> !invalid_o);

  for (genvar p = 0; p < NPAIR; p++) begin : g_lane
    assert_even_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && !dn_mode_i |=> dst0_o[32*p+31] == $past(src_i[32*p+15]));

    assert_odd_sign_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && !dn_mode_i |=> dst1_o[32*p+31] == $past(src_i[32*p+31]));

    assert_inf_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && src_i[32*p +: 15] == 15'h7C00 |=> dst0_o[32*p +: 31] == 31'h7F80_0000);

    assert_dnan_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && dn_mode_i |=> dst1_o[32*p+23 +: 8] != 8'hFF || dst1_o[32*p +: 23] == '0
                               || dst1_o[32*p +: 32] == 32'h7FC0_0000);
  end
endmodule

bind fp16_deint_widen fp16_deint_widen_chk #(.VL(VL)) u_chk (.*);

// File: tb/sim_fp16_deint_widen.sv
`timescale 1ns/1ps
module sim_fp16_deint_widen;
  localparam int VL0 = 128;
  localparam int VL1 = 256;
  localparam int N0  = VL0 / 32;
  localparam int N1  = VL1 / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           valid0 = 1'b0, dn0 = 1'b0;
  logic [VL0-1:0] src0 = '0;
  logic           vout0, inv0;
  logic [VL0-1:0] d00, d01;

  logic           valid1 = 1'b0, dn1 = 1'b0;
  logic [VL1-1:0] src1 = '0;
  logic           vout1, inv1;
  logic [VL1-1:0] d10, d11;

  fp16_deint_widen #(.VL(VL0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid0), .src_i(src0), .dn_mode_i(dn0),
    .valid_o(vout0), .dst0_o(d00), .dst1_o(d01), .invalid_o(inv0));

  fp16_deint_widen #(.VL(VL1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid1), .src_i(src1), .dn_mode_i(dn1),
    .valid_o(vout1), .dst0_o(d10), .dst1_o(d11), .invalid_o(inv1));

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [VL0-1:0] e0;
    logic [VL0-1:0] e1;
    logic           inv;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  last_exp;

  function automatic logic [32:0] ref_cvt(input logic [15:0] h, input logic dn);
    logic s; logic [4:0] e; logic [9:0] f;
    s = h[15]; e = h[14:10]; f = h[9:0];
    if (e == 5'd31) begin
      if (f == 0) return {1'b0, s, 8'hFF, 23'h0};
      if (dn) return {~f[9], 32'h7FC0_0000};
      return {~f[9], s, 8'hFF, 1'b1, f[8:0], 13'h0};
    end
    if (e == 0 && f == 0) return {1'b0, s, 31'h0};
    if (e == 0) begin
      int ex = -14;
      logic [10:0] m = {1'b0, f};
      while (!m[10]) begin m = m << 1; ex--; end
      return {1'b0, s, 8'(ex + 127), m[9:0], 13'h0};
    end
    return {1'b0, s, 8'(int'(e) - 15 + 127), f, 13'h0};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic send(input logic [VL0-1:0] src, input logic dn, input string tag);
    exp_t x;
    logic [32:0] r;
    x = '0;
    for (int p = 0; p < N0; p++) begin
      r = ref_cvt(src[32*p +: 16], dn);
      x.e0[32*p +: 32] = r[31:0];
      x.inv |= r[32];
      r = ref_cvt(src[32*p + 16 +: 16], dn);
      x.e1[32*p +: 32] = r[31:0];
      x.inv |= r[32];
    end
    @(negedge clk);
    valid0 = 1'b1; src0 = src; dn0 = dn;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic idle0;
    @(negedge clk);
    valid0 = 1'b0;
  endtask

  // monitor: one operation retires per valid_o
  always @(negedge clk) begin
    if (rst_n && vout0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected valid_o", 32'(vout0), 32'h0);
      end else begin
        exp_t x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = x;
        for (int p = 0; p < N0; p++) begin
          check(d00[32*p +: 32] == x.e0[32*p +: 32], $sformatf("R2 %s lane %0d", t, p),
                d00[32*p +: 32], x.e0[32*p +: 32]);
          check(d01[32*p +: 32] == x.e1[32*p +: 32], $sformatf("R3 %s lane %0d", t, p),
                d01[32*p +: 32], x.e1[32*p +: 32]);
        end
        check(inv0 == x.inv, $sformatf("R9 %s flag", t), 32'(inv0), 32'(x.inv));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1 watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [VL0-1:0] v;
    logic [32:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(vout0 == 1'b0, "R1 reset valid_o", 32'(vout0), 32'h0);
    check(d00 == '0 && d01 == '0, "R1 reset dst", d00[31:0] | d01[31:0], 32'h0);
    check(inv0 == 1'b0, "R1 reset flag", 32'(inv0), 32'h0);

    // R2 R3 placement with distinct lanes
    for (int i = 0; i < 8; i++) v[16*i +: 16] = 16'h3C00 + 16'(i * 16'h0111);
    send(v, 1'b0, "placement");

    // R9 flag cases
    v = {8{16'h3C00}};
    v[16*5 +: 16] = 16'h7D00;
    send(v, 1'b0, "R9 one snan");
    send({8{16'h7E00}}, 1'b0, "R9 qnan no flag");
    send({16'h7C00, 16'hFC00, 16'h8000, 16'h0000, 16'h7BFF, 16'h0401, 16'h03FF, 16'h8001},
         1'b0, "R5 R6 specials");

    // exhaustive sweep, both NaN modes
    for (int b = 0; b < 65536; b += 8) begin
      for (int i = 0; i < 8; i++) v[16*i +: 16] = 16'(b + i);
      send(v, 1'b0, "R4 R5 R6 R7 sweep");
    end
    for (int b = 0; b < 65536; b += 8) begin
      for (int i = 0; i < 8; i++) v[16*i +: 16] = 16'(b + i);
      send(v, 1'b1, "R8 sweep");
    end
    idle0();
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R1 scoreboard drained", 32'(exp_q.size()), 32'h0);

    // R10 hold while idle with changing source
    src0 = {8{16'h7D55}};
    dn0 = 1'b1;
    repeat (3) @(negedge clk);
    check(d00 == last_exp.e0, "R10 dst0 hold", d00[31:0], last_exp.e0[31:0]);
    check(d01 == last_exp.e1, "R10 dst1 hold", d01[31:0], last_exp.e1[31:0]);
    check(inv0 == last_exp.inv, "R10 flag hold", 32'(inv0), 32'(last_exp.inv));

    // second width: lane placement at VL 256
    for (int pat = 0; pat < 2; pat++) begin
      for (int i = 0; i < 2 * N1; i++)
        src1[16*i +: 16] = (pat == 0) ? 16'h4000 + 16'(i * 16'h0123)
                                      : {i[0], 5'd0, 10'(1 << (i % 10))};
      @(negedge clk);
      valid1 = 1'b1;
      dn1 = 1'b0;
      @(negedge clk);
      valid1 = 1'b0;
      check(vout1 == 1'b1, "R1 wide valid_o", 32'(vout1), 32'h1);
      for (int p = 0; p < N1; p++) begin
        r = ref_cvt(src1[32*p +: 16], 1'b0);
        check(d10[32*p +: 32] == r[31:0], $sformatf("R2 wide lane %0d", p), d10[32*p +: 32], r[31:0]);
        r = ref_cvt(src1[32*p + 16 +: 16], 1'b0);
        check(d11[32*p +: 32] == r[31:0], $sformatf("R3 wide lane %0d", p), d11[32*p +: 32], r[31:0]);
      end
    end
    finish_run();
  end
endmodule